// File: doc/BRIEF.md
# Modular-Exponentiation Accelerator Register Front-End

This block is the bus-facing side of a modular-exponentiation accelerator. Software reaches it over a plain 32-bit register bus with an address, a write strobe, a read strobe, write data and read data. It holds three operand stores of 128 words each: the modulus, the exponent, and a shared store for the operand and the result. Each store is reached through its own data window. A pointer register sets the word position in that store, and every access through the window moves the pointer on by one word.

The block also holds the configuration, control, interrupt-enable and interrupt-status registers. It has a soft reset that clears itself, and it runs the start, busy and done sequence. The arithmetic engine is outside this block. The block meets it through a handshake: a start pulse out with the key-width code and the mode, a done strobe in, and a write port through which the engine places result words into the shared store.

Operands are packed least-significant byte first, and word 0 carries the least-significant 32 bits of the number. A big-endian byte string is therefore byte-reversed by software while it is loaded. The block itself moves whole words and does no byte swapping.

Top module: `mxa_regfront`

## Requirements
- R1: After `rst_n` is released, every register reads 0 and `irq` is low. The registers are: configuration 0x00, control 0x04, interrupt enable 0x08, status 0x0C, and the pointers at 0x14, 0x1C and 0x24.
- R2: A write to a pointer register sets that store's word position from the write data bits [6:0]. Each read or write of the matching data window moves the position on by one word, and position 127 wraps to 0.
- R3: The modulus store (window 0x10, pointer 0x14), the exponent store (window 0x18, pointer 0x1C) and the shared store (window 0x20, pointer 0x24) each keep 128 independent words. A word written through a window reads back unchanged.
- R4: Writing 1 to control bit 0 while idle, with a key-width code of 4 or less, starts an operation. `eng_start` pulses high for one cycle. Status bit 1 (busy) reads 1. `eng_width` carries configuration bits [3:1] and `eng_mode` carries configuration bits [7:4].
- R5: While busy, a cycle with `eng_done` high clears busy and sets status bit 0 (done) at the next clock edge.
- R6: Writing 1 to status bit 0 clears done. Writing 0 there leaves done unchanged.
- R7: `irq` is high exactly when done is set and interrupt-enable bit 0 is 1.
- R8: A start request is ignored while busy, and also when the key-width code is 5, 6 or 7. In that case there is no `eng_start` pulse, busy does not change and done is not set.
- R9: While busy, reads of any data window return 0, writes to it leave the store unchanged, and its pointer does not move.
- R10: Writing 1 to configuration bit 0 starts a soft reset. The bit reads 1 for RST_CYCLES cycles and then clears by itself. The reset clears busy, done, control and all three pointers, and leaves the stores unchanged.
- R11: Words that the engine writes through its write port during an operation are read back through the shared data window, starting at the position last written to its pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (advances window pointers) |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data for the current address |
| irq | output | 1 | Done interrupt, gated by enable |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_width | output | 3 | Key-width code (256 << code bits) |
| eng_mode | output | MODE_W | Operation mode to the engine |
| eng_done | input | 1 | Engine completion strobe |
| eng_wr_en | input | 1 | Engine write into the shared store |
| eng_wr_addr | input | PTR_W | Engine write word position |
| eng_wr_data | input | DATA_W | Engine write word |

## Verification
Each of the three stores is filled end to end with a pattern unique to that store, then read back. This exposes crossed bank decoding and a lost or doubled pointer step, and it lands on the 127-to-0 wrap. A short write starting at position 126 tells a true wrap apart from a pointer that saturates. A full operation is then run with a stub engine that writes distinct result words, so the result readback cannot be confused with the staged input. During that run, a window write made while busy must leave the word at the parked pointer with its staged value. Start requests made while busy and with width codes above 4 must produce no pulse and no done. A soft reset issued in the middle of an operation must return the control state to idle while the modulus contents stay as they were.

// File: rtl/mxa_pkg.sv
package mxa_pkg;

  // Fixed register offsets (byte addresses)
  localparam logic [7:0] OFS_CFG  = 8'h00;
  localparam logic [7:0] OFS_CTRL = 8'h04;
  localparam logic [7:0] OFS_IEN  = 8'h08;
  localparam logic [7:0] OFS_STS  = 8'h0C;
  localparam logic [7:0] BANK_BASE = 8'h10;
  localparam int unsigned BANK_STRIDE = 8;

  // Largest supported key-width code (256 << 4 = 4096 bits)
  localparam logic [2:0] MAX_WIDTH_CODE = 3'd4;

  // Bank order: 0 modulus, 1 exponent, 2 shared data/result
  localparam int unsigned NBANK = 3;

  function automatic logic [7:0] bank_data_ofs(input int unsigned b);
    return 8'(BANK_BASE + BANK_STRIDE * b);
  endfunction

  function automatic logic [7:0] bank_ptr_ofs(input int unsigned b);
    return 8'(BANK_BASE + BANK_STRIDE * b + 4);
  endfunction

  function automatic logic width_code_ok(input logic [2:0] code);
    return code <= MAX_WIDTH_CODE;
  endfunction

endpackage

// File: rtl/mxa_operand_bank.sv
module mxa_operand_bank #(
  parameter int unsigned WORDS  = 128,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned PTR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              blocked,
  input  logic              ptr_we,
  input  logic [PTR_W-1:0]  ptr_wdata,
  input  logic              dat_we,
  input  logic              dat_re,
  input  logic [DATA_W-1:0] dat_wdata,
  input  logic              eng_we,
  input  logic [PTR_W-1:0]  eng_addr,
  input  logic [DATA_W-1:0] eng_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [PTR_W-1:0]  ptr,
  output logic              advance
);

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(WORDS - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [DATA_W-1:0] mem [WORDS];
  logic [PTR_W-1:0]  ptr_q;
  logic              bus_wr;

  assign advance = (dat_we | dat_re) & ~blocked;
  assign bus_wr  = dat_we & ~blocked;

  always_ff @(posedge clk) begin
    if (bus_wr) mem[ptr_q] <= dat_wdata;
    if (eng_we) mem[eng_addr] <= eng_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr_q <= '0;
    else if (clr)      ptr_q <= '0;
    else if (ptr_we)   ptr_q <= ptr_wdata;
    else if (advance)  ptr_q <= next_ptr(ptr_q);
  end

  assign ptr     = ptr_q;
  assign rd_data = blocked ? '0 : mem[ptr_q];

endmodule

// File: rtl/mxa_seq.sv
module mxa_seq #(
  parameter int unsigned MODE_W     = 4,
  parameter int unsigned RST_CYCLES = 4,
  localparam int unsigned CNT_W     = $clog2(RST_CYCLES) + 1,
  localparam int unsigned CW        = 4 + MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     wdata,
  input  logic              cfg_we,
  input  logic              ctrl_we,
  input  logic              ien_we,
  input  logic              sts_we,
  input  logic              eng_done,
  output logic              srst,
  output logic              busy,
  output logic              done,
  output logic              ctrl_bit,
  output logic              ien_bit,
  output logic [2:0]        width,
  output logic [MODE_W-1:0] mode,
  output logic              eng_start,
  output logic              start_acc,
  output logic              start_rej,
  output logic              finish,
  output logic              irq
);

  logic             srst_q, busy_q, done_q, ctrl_q, ien_q, start_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       width_q;
  logic [MODE_W-1:0] mode_q;

  assign start_acc = ctrl_we & wdata[0] & ~busy_q & ~srst_q & mxa_pkg::width_code_ok(width_q);
  assign start_rej = ctrl_we & wdata[0] & ~start_acc;
  assign finish    = busy_q & eng_done & ~srst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q  <= 1'b0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      ctrl_q  <= 1'b0;
      ien_q   <= 1'b0;
      start_q <= 1'b0;
      width_q <= '0;
      mode_q  <= '0;
    end else begin
      start_q <= 1'b0;
      if (cfg_we) begin
        width_q <= wdata[3:1];
        mode_q  <= wdata[4 +: MODE_W];
      end
      if (cfg_we && wdata[0]) begin
        srst_q <= 1'b1;
        cnt_q  <= CNT_W'(RST_CYCLES - 1);
      end else if (srst_q) begin
        if (cnt_q == '0) srst_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
      if (ien_we) ien_q <= wdata[0];
      if (srst_q) begin
        busy_q <= 1'b0;
        done_q <= 1'b0;
        ctrl_q <= 1'b0;
      end else begin
        if (ctrl_we) ctrl_q <= wdata[0];
        if (start_acc) begin
          busy_q  <= 1'b1;
          start_q <= 1'b1;
        end else if (finish) begin
          busy_q <= 1'b0;
        end
        if (finish)                   done_q <= 1'b1;
        else if (sts_we && wdata[0])  done_q <= 1'b0;
      end
    end
  end

  assign srst      = srst_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign ctrl_bit  = ctrl_q;
  assign ien_bit   = ien_q;
  assign width     = width_q;
  assign mode      = mode_q;
  assign eng_start = start_q;
  assign irq       = done_q & ien_q;

endmodule

// File: rtl/mxa_regfront.sv
module mxa_regfront #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned WORDS      = 128,
  parameter int unsigned MODE_W     = 4,
  parameter int unsigned RST_CYCLES = 4,
  localparam int unsigned PTR_W     = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              eng_start,
  output logic [2:0]        eng_width,
  output logic [MODE_W-1:0] eng_mode,
  input  logic              eng_done,
  input  logic              eng_wr_en,
  input  logic [PTR_W-1:0]  eng_wr_addr,
  input  logic [DATA_W-1:0] eng_wr_data
);
  import mxa_pkg::*;

  localparam int unsigned CW = 4 + MODE_W;

  // Named internal events, visible to the bound checker
  logic              cfg_we, ctrl_we, ien_we, sts_we, sts_clr;
  logic              srst_w, busy_w, done_w, ctrl_w, ien_w;
  logic              start_acc, start_rej, finish;
  logic              eng_we_g, ptr_any_we;
  logic [NBANK-1:0]  dat_we, dat_re, ptr_we, adv;
  logic [DATA_W-1:0] bank_rd  [NBANK];
  logic [PTR_W-1:0]  bank_ptr [NBANK];

  assign cfg_we   = bus_we && (bus_addr == ADDR_W'(OFS_CFG));
  assign ctrl_we  = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
  assign ien_we   = bus_we && (bus_addr == ADDR_W'(OFS_IEN));
  assign sts_we   = bus_we && (bus_addr == ADDR_W'(OFS_STS));
  assign sts_clr  = sts_we && bus_wdata[0];
  assign eng_we_g = eng_wr_en && busy_w;
  assign ptr_any_we = |ptr_we;

  mxa_seq #(.MODE_W(MODE_W), .RST_CYCLES(RST_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .wdata(bus_wdata[CW-1:0]),
    .cfg_we(cfg_we), .ctrl_we(ctrl_we), .ien_we(ien_we), .sts_we(sts_we),
    .eng_done(eng_done), .srst(srst_w), .busy(busy_w), .done(done_w),
    .ctrl_bit(ctrl_w), .ien_bit(ien_w), .width(eng_width), .mode(eng_mode),
    .eng_start(eng_start), .start_acc(start_acc), .start_rej(start_rej),
    .finish(finish), .irq(irq)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] DAT_OFS = ADDR_W'(bank_data_ofs(b));
    localparam logic [ADDR_W-1:0] PTR_OFS = ADDR_W'(bank_ptr_ofs(b));
    localparam bit IS_SHARED = (b == NBANK - 1);

    assign dat_we[b] = bus_we && (bus_addr == DAT_OFS);
    assign dat_re[b] = bus_re && (bus_addr == DAT_OFS);
    assign ptr_we[b] = bus_we && (bus_addr == PTR_OFS);

    mxa_operand_bank #(.WORDS(WORDS), .DATA_W(DATA_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .clr(srst_w), .blocked(busy_w),
      .ptr_we(ptr_we[b]), .ptr_wdata(bus_wdata[PTR_W-1:0]),
      .dat_we(dat_we[b]), .dat_re(dat_re[b]), .dat_wdata(bus_wdata),
      .eng_we(IS_SHARED ? eng_we_g : 1'b0),
      .eng_addr(eng_wr_addr), .eng_wdata(eng_wr_data),
      .rd_data(bank_rd[b]), .ptr(bank_ptr[b]), .advance(adv[b])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_CFG))
      bus_rdata = DATA_W'({eng_mode, eng_width, srst_w});
    else if (bus_addr == ADDR_W'(OFS_CTRL))
      bus_rdata = DATA_W'(ctrl_w);
    else if (bus_addr == ADDR_W'(OFS_IEN))
      bus_rdata = DATA_W'(ien_w);
    else if (bus_addr == ADDR_W'(OFS_STS))
      bus_rdata = DATA_W'({busy_w, done_w});
    for (int b = 0; b < NBANK; b++) begin
      if (bus_addr == ADDR_W'(bank_data_ofs(b))) bus_rdata = bank_rd[b];
      if (bus_addr == ADDR_W'(bank_ptr_ofs(b)))  bus_rdata = DATA_W'(bank_ptr[b]);
    end
  end

endmodule

// File: rtl/mxa_regfront_chk.sv
module mxa_regfront_chk #(
  parameter int unsigned WORDS = 128,
  localparam int unsigned PTR_W = $clog2(WORDS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eng_start,
  input logic             eng_done,
  input logic             irq,
  input logic             busy,
  input logic             done,
  input logic             srst,
  input logic             start_acc,
  input logic             start_rej,
  input logic             sts_clr,
  input logic             shared_ptr_we,
  input logic             shared_adv,
  input logic [PTR_W-1:0] shared_ptr
);

  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (busy && eng_start));

  assert_finish_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_done && !srst) |=> (done && !busy));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && !(busy && eng_done)) |=> !done);

  assert_irq_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && !(busy && eng_done)) |=> !irq);

  assert_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_rej |=> !eng_start);

  assert_hold_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !srst && !shared_ptr_we) |=> $stable(shared_ptr));

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shared_adv && !shared_ptr_we && !srst && shared_ptr == PTR_W'(WORDS - 1))
      |=> (shared_ptr == '0));

  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!busy && !done && shared_ptr == '0));

endmodule

bind mxa_regfront mxa_regfront_chk #(.WORDS(WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .eng_start(eng_start), .eng_done(eng_done),
  .irq(irq), .busy(busy_w), .done(done_w), .srst(srst_w),
  .start_acc(start_acc), .start_rej(start_rej), .sts_clr(sts_clr),
  .shared_ptr_we(ptr_we[mxa_pkg::NBANK-1]), .shared_adv(adv[mxa_pkg::NBANK-1]),
  .shared_ptr(bank_ptr[mxa_pkg::NBANK-1])
);

// File: tb/mxa_regfront_bench.sv
module mxa_regfront_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 128;
  localparam int RSTC  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, eng_start;
  logic [2:0]  eng_width;
  logic [3:0]  eng_mode;
  logic        eng_done = 1'b0, eng_wr_en = 1'b0;
  logic [6:0]  eng_wr_addr = '0;
  logic [31:0] eng_wr_data = '0;

  int n_checks = 0;
  int n_err = 0;
  logic [31:0] model [3][WORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  mxa_regfront u_mxa_regfront (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .eng_start(eng_start),
    .eng_width(eng_width), .eng_mode(eng_mode), .eng_done(eng_done),
    .eng_wr_en(eng_wr_en), .eng_wr_addr(eng_wr_addr), .eng_wr_data(eng_wr_data)
  );

  function automatic logic [7:0] win(input int b);  return 8'(8'h10 + 8*b); endfunction
  function automatic logic [7:0] pofs(input int b); return 8'(8'h14 + 8*b); endfunction
  function automatic logic [31:0] pat(input int b, input int i);
    return {8'(8'hB0 + b), 8'(i), 8'(~i), 8'(i * 3 + b)};
  endfunction
  function automatic logic [31:0] res(input int i);
    return 32'h5E5E_0000 | 32'(i * 17);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_re = 1'b0;
  endtask

  task automatic engine(input int nwr);
    for (int i = 0; i < nwr; i++) begin
      @(negedge clk);
      eng_wr_en = 1'b1; eng_wr_addr = 7'(i); eng_wr_data = res(i);
    end
    @(negedge clk);
    eng_wr_en = 1'b0; eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    foreach (model[b, i]) model[b][i] = 'x;
    rd(8'h00, v); check("R1 cfg", v, 0);
    rd(8'h04, v); check("R1 ctrl", v, 0);
    rd(8'h08, v); check("R1 ien", v, 0);
    rd(8'h0C, v); check("R1 status", v, 0);
    for (int b = 0; b < 3; b++) begin rd(pofs(b), v); check("R1 pointer", v, 0); end
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_fill;
    logic [31:0] v;
    for (int b = 0; b < 3; b++) begin
      wr(pofs(b), 0);
      for (int i = 0; i < WORDS; i++) begin wr(win(b), pat(b, i)); model[b][i] = pat(b, i); end
      rd(pofs(b), v); check("R2 wrap after full fill", v, 0);
    end
    for (int b = 0; b < 3; b++)
      for (int i = 0; i < WORDS; i++) begin rd(win(b), v); check("R3 readback", v, model[b][i]); end
  endtask

  task automatic t_window;
    logic [31:0] v;
    wr(pofs(2), 126);
    wr(win(2), 32'hAAAA_0001); wr(win(2), 32'hAAAA_0002); wr(win(2), 32'hAAAA_0003);
    model[2][126] = 32'hAAAA_0001; model[2][127] = 32'hAAAA_0002; model[2][0] = 32'hAAAA_0003;
    rd(pofs(2), v); check("R2 pointer after wrap", v, 1);
    wr(pofs(2), 126);
    rd(win(2), v); check("R2 word 126", v, 32'hAAAA_0001);
    rd(win(2), v); check("R2 word 127", v, 32'hAAAA_0002);
    rd(win(2), v); check("R2 word 0 after wrap", v, 32'hAAAA_0003);
    wr(pofs(0), 0);
    rd(win(0), v); check("R3 modulus untouched", v, model[0][0]);
  endtask

  task automatic t_operation;
    logic [31:0] v;
    wr(8'h00, 32'h26);
    wr(8'h08, 1);
    wr(pofs(2), 20);
    wr(8'h04, 1);
    check("R4 start pulse", 32'(eng_start), 1);
    check("R4 width", 32'(eng_width), 3);
    check("R4 mode", 32'(eng_mode), 2);
    rd(8'h0C, v); check("R4 busy status", v, 2);
    check("R4 pulse single", 32'(eng_start), 0);
    rd(win(2), v); check("R9 read while busy", v, 0);
    wr(win(2), 32'hDEAD_BEEF);
    rd(pofs(2), v); check("R9 pointer held", v, 20);
    check("R7 irq low while busy", 32'(irq), 0);
    engine(8);
    rd(8'h0C, v); check("R5 done status", v, 1);
    check("R7 irq", 32'(irq), 1);
    wr(pofs(2), 0);
    for (int i = 0; i < 8; i++) begin rd(win(2), v); check("R11 result word", v, res(i)); model[2][i] = res(i); end
    wr(pofs(2), 20);
    rd(win(2), v); check("R9 write ignored", v, model[2][20]);
    wr(8'h0C, 0);
    rd(8'h0C, v); check("R6 write 0 keeps done", v, 1);
    wr(8'h0C, 1);
    rd(8'h0C, v); check("R6 done cleared", v, 0);
    check("R7 irq cleared", 32'(irq), 0);
  endtask

  task automatic t_busy_start;
    logic [31:0] v;
    wr(8'h08, 0);
    wr(8'h04, 1);
    check("R8 first start", 32'(eng_start), 1);
    wr(8'h04, 1);
    check("R8 start while busy ignored", 32'(eng_start), 0);
    rd(8'h0C, v); check("R8 still busy", v, 2);
    engine(0);
    rd(8'h0C, v); check("R5 done once", v, 1);
    check("R7 irq masked", 32'(irq), 0);
    wr(8'h0C, 1);
  endtask

  task automatic t_bad_width;
    logic [31:0] v;
    wr(8'h00, 32'h0A);
    rd(8'h00, v); check("R4 cfg readback", v, 32'h0A);
    wr(8'h04, 1);
    check("R8 bad width no pulse", 32'(eng_start), 0);
    rd(8'h0C, v); check("R8 bad width not busy", v, 0);
    repeat (3) @(negedge clk);
    rd(8'h0C, v); check("R8 bad width no done", v, 0);
  endtask

  task automatic t_soft_reset;
    logic [31:0] v;
    int polls;
    wr(8'h00, 32'h06);
    wr(8'h04, 1);
    wr(pofs(0), 5);
    wr(pofs(1), 9);
    wr(8'h00, 32'h01);
    rd(8'h00, v); check("R10 reset bit set", v & 1, 1);
    polls = 1;
    while ((v & 1) != 0 && polls < 2 * RSTC) begin rd(8'h00, v); polls++; end
    check("R10 reset bit self-clears", v & 1, 0);
    rd(8'h0C, v); check("R10 status cleared", v, 0);
    rd(8'h04, v); check("R10 control cleared", v, 0);
    for (int b = 0; b < 3; b++) begin rd(pofs(b), v); check("R10 pointer cleared", v, 0); end
    rd(win(0), v); check("R10 memory kept", v, model[0][0]);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_window();
    t_operation();
    t_busy_start();
    t_bad_width();
    t_soft_reset();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule